// File: doc/BRIEF.md
# Latched position byte readout

This block lets an 8-bit host read a 32-bit position count without tearing. Two axes each present a live 32-bit count. Each axis has a position latch that copies its count on every rising clock edge while the axis is idle. When the host pulls the active-low output enable low, that axis's latch is frozen. The host then picks bytes one at a time with two byte-select inputs. All four bytes therefore come from one snapshot, and the count source keeps counting in the meantime.

The output enable, the byte selects and the axis select are captured on the falling clock edge. The rising edge that follows acts on those captured values. A frozen axis stays frozen until two things have been captured in this order: a least-significant-byte access, then output enable high. After that the latch starts tracking the count again. Each axis has its own asynchronous active-low reset. It clears that axis's latch and its inhibit state.

The data bus is meant to feed a tri-state buffer. The drive-enable output is high exactly while output enable is low. While the bus is not enabled the data bits are held at zero.

Top module: `pos_byte_reader`

## Requirements
- R1: Byte select code {bsel1,bsel2} picks the latched byte: 2'b01 gives bits 31:24, 2'b11 gives bits 23:16, 2'b00 gives bits 15:8, 2'b10 gives bits 7:0.
- R2: With oe_n high, data_drv is 0 and data_out is 0. With oe_n low, data_drv is 1 and data_out carries the selected byte, combinationally from the present inputs.
- R3: axis_sel low reads the latch of axis 1 (count_ax1). axis_sel high reads the latch of axis 2 (count_ax2).
- R4: While an axis is not inhibited, its latch loads the live count on every rising edge. A read that begins after such an edge returns the count present at that edge.
- R5: A low oe_n captured on a falling edge, with axis_sel selecting an axis, sets that axis's inhibit and stops its latch from loading at the next rising edge. Count changes made from that point on are not seen until release.
- R6: An inhibited axis is released only after an LSB access (code 2'b10 with oe_n low) has been captured and, after that, oe_n high has been captured. Returning oe_n high without an LSB access keeps the latch frozen.
- R7: After release, the latch tracks the count again from the second rising edge onward. The next read returns the count's current value, so no counts are lost.
- R8: Driving rst_ax1_n or rst_ax2_n low clears that axis's latch to zero and its inhibit. The other axis is not affected.
- R9: Freezing one axis has no effect on the other, which keeps tracking its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; controls are captured on the falling edge, the latch updates on the rising edge |
| rst_ax1_n | input | 1 | Asynchronous active-low reset for axis 1 |
| rst_ax2_n | input | 1 | Asynchronous active-low reset for axis 2 |
| count_ax1 | input | 32 | Live position count, axis 1 |
| count_ax2 | input | 32 | Live position count, axis 2 |
| axis_sel | input | 1 | 0 selects axis 1, 1 selects axis 2 |
| bsel1 | input | 1 | Byte select, upper code bit |
| bsel2 | input | 1 | Byte select, lower code bit |
| oe_n | input | 1 | Active-low output enable; also starts the freeze |
| data_out | output | 8 | Selected latched byte, zero when not enabled |
| data_drv | output | 1 | Drive-enable for the external tri-state buffer |

## Verification
Two events can land on the same rising edge: the latch reload and the freeze. The bench provokes this by changing the live count in the same step that pulls oe_n low. It then checks that the byte read is the count loaded at the previous edge, and that this value survives later count changes. A second collision pairs an asynchronous axis reset with a frozen snapshot. It is judged by reading the reset axis as zero while the other axis still returns its own value.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  // Byte select codes, written as {bsel1, bsel2}.
  localparam logic [1:0] BSEL_TOP   = 2'b01;
  localparam logic [1:0] BSEL_UPPER = 2'b11;
  localparam logic [1:0] BSEL_LOWER = 2'b00;
  localparam logic [1:0] BSEL_LEAST = 2'b10;

  // Rank of a byte inside the word, 0 = least significant.
  function automatic logic [1:0] byte_rank(input logic [1:0] code);
    logic [1:0] r;
    unique case (code)
      BSEL_TOP:   r = 2'd3;
      BSEL_UPPER: r = 2'd2;
      BSEL_LOWER: r = 2'd1;
      default:    r = 2'd0;
    endcase
    return r;
  endfunction

  function automatic logic is_least(input logic [1:0] code);
    return code == BSEL_LEAST;
  endfunction

endpackage

// File: rtl/pbr_sampler.sv
module pbr_sampler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oe_n,
  input  logic [1:0] bsel,
  input  logic       axis_sel,
  output logic       oe_n_s,
  output logic [1:0] bsel_s,
  output logic       axis_s
);
  // Control inputs are captured on the falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_n_s <= 1'b1;
      bsel_s <= 2'b00;
      axis_s <= 1'b0;
    end else begin
      oe_n_s <= oe_n;
      bsel_s <= bsel;
      axis_s <= axis_sel;
    end
  end
endmodule

// File: rtl/pbr_inhibit.sv
module pbr_inhibit
  import pbr_pkg::*;
#(
  parameter logic AXIS_ID = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oe_n_s,
  input  logic [1:0] bsel_s,
  input  logic       axis_s,
  output logic       inhibit,
  output logic       lsb_seen,
  output logic       claim,
  output logic       load_en
);
  logic release_now;

  assign claim       = !oe_n_s && (axis_s == AXIS_ID);
  assign release_now = oe_n_s && lsb_seen;
  assign load_en     = !inhibit && !claim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit  <= 1'b0;
      lsb_seen <= 1'b0;
    end else if (claim) begin
      inhibit <= 1'b1;
      if (is_least(bsel_s)) lsb_seen <= 1'b1;
    end else if (release_now) begin
      inhibit  <= 1'b0;
      lsb_seen <= 1'b0;
    end
  end
endmodule

// File: rtl/pbr_pos_latch.sv
module pbr_pos_latch #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (load_en) held <= count;
  end
endmodule

// File: rtl/pbr_byte_mux.sv
module pbr_byte_mux
  import pbr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic [CNT_W-1:0]  word_a,
  input  logic [CNT_W-1:0]  word_b,
  input  logic              axis_sel,
  input  logic [1:0]        bsel,
  input  logic              oe_n,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_drv
);
  logic [CNT_W-1:0]  word;
  logic [1:0]        rank;
  logic [BYTE_W-1:0] picked;

  assign word   = axis_sel ? word_b : word_a;
  assign rank   = byte_rank(bsel);
  assign picked = word[rank*BYTE_W +: BYTE_W];

  assign data_drv = !oe_n;
  assign data_out = oe_n ? '0 : picked;
endmodule

// File: rtl/pos_byte_reader.sv
module pos_byte_reader #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_ax1_n,
  input  logic              rst_ax2_n,
  input  logic [CNT_W-1:0]  count_ax1,
  input  logic [CNT_W-1:0]  count_ax2,
  input  logic              axis_sel,
  input  logic              bsel1,
  input  logic              bsel2,
  input  logic              oe_n,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_drv
);
  localparam int N_AXES = 2;

  logic [1:0]                        bsel;
  logic [N_AXES-1:0]                 rst_n_w;
  logic [N_AXES-1:0][CNT_W-1:0]      count_w;
  logic [N_AXES-1:0][CNT_W-1:0]      latch_w;
  logic [N_AXES-1:0]                 inhib_w;
  logic [N_AXES-1:0]                 lsb_seen_w;
  logic [N_AXES-1:0]                 claim_w;
  logic [N_AXES-1:0]                 load_w;

  assign bsel       = {bsel1, bsel2};
  assign rst_n_w    = {rst_ax2_n, rst_ax1_n};
  assign count_w[0] = count_ax1;
  assign count_w[1] = count_ax2;

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    logic       oe_n_s;
    logic [1:0] bsel_s;
    logic       axis_s;

    pbr_sampler u_smp (
      .clk      (clk),
      .rst_n    (rst_n_w[a]),
      .oe_n     (oe_n),
      .bsel     (bsel),
      .axis_sel (axis_sel),
      .oe_n_s   (oe_n_s),
      .bsel_s   (bsel_s),
      .axis_s   (axis_s)
    );

    pbr_inhibit #(.AXIS_ID(1'(a))) u_inh (
      .clk      (clk),
      .rst_n    (rst_n_w[a]),
      .oe_n_s   (oe_n_s),
      .bsel_s   (bsel_s),
      .axis_s   (axis_s),
      .inhibit  (inhib_w[a]),
      .lsb_seen (lsb_seen_w[a]),
      .claim    (claim_w[a]),
      .load_en  (load_w[a])
    );

    pbr_pos_latch #(.CNT_W(CNT_W)) u_lat (
      .clk     (clk),
      .rst_n   (rst_n_w[a]),
      .load_en (load_w[a]),
      .count   (count_w[a]),
      .held    (latch_w[a])
    );
  end

  pbr_byte_mux #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_mux (
    .word_a   (latch_w[0]),
    .word_b   (latch_w[1]),
    .axis_sel (axis_sel),
    .bsel     (bsel),
    .oe_n     (oe_n),
    .data_out (data_out),
    .data_drv (data_drv)
  );
endmodule

// File: rtl/pbr_checker.sv
module pbr_checker #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8
) (
  input logic                   clk,
  input logic                   oe_n,
  input logic [BYTE_W-1:0]      data_out,
  input logic                   data_drv,
  input logic [1:0]             rst_n_w,
  input logic [1:0][CNT_W-1:0]  count_w,
  input logic [1:0][CNT_W-1:0]  latch_w,
  input logic [1:0]             inhib_w,
  input logic [1:0]             lsb_seen_w,
  input logic [1:0]             claim_w,
  input logic [1:0]             load_w
);
  // R2: a disabled bus is quiet.
  p_idle_bus_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_w[0])
    oe_n |-> (!data_drv && data_out == '0));

  // R2: an enabled bus is driven.
  p_drive_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n_w[0])
    !oe_n |-> data_drv);

  for (genvar a = 0; a < 2; a++) begin : g_chk
    // R4: a load edge copies the live count.
    p_track_count_r4: assert property (@(posedge clk) disable iff (!rst_n_w[a])
      load_w[a] |=> latch_w[a] == $past(count_w[a]));

    // R5: a claim captured on the falling edge raises inhibit.
    p_claim_sets_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n_w[a])
      claim_w[a] |=> inhib_w[a]);

    // R5: an inhibited latch holds.
    p_frozen_latch_r5: assert property (@(posedge clk) disable iff (!rst_n_w[a])
      inhib_w[a] |=> $stable(latch_w[a]));

    // R6: no release before an LSB access.
    p_hold_until_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n_w[a])
      (inhib_w[a] && !lsb_seen_w[a]) |=> inhib_w[a]);
  end
endmodule

bind pos_byte_reader pbr_checker #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .oe_n       (oe_n),
  .data_out   (data_out),
  .data_drv   (data_drv),
  .rst_n_w    (rst_n_w),
  .count_w    (count_w),
  .latch_w    (latch_w),
  .inhib_w    (inhib_w),
  .lsb_seen_w (lsb_seen_w),
  .claim_w    (claim_w),
  .load_w     (load_w)
);

// File: tb/tb_pos_byte_reader.sv
`timescale 1ns/1ps
module tb_pos_byte_reader;
  logic        clk = 1'b0;
  logic        rst_ax1_n, rst_ax2_n;
  logic [31:0] count_ax1, count_ax2;
  logic        axis_sel, bsel1, bsel2, oe_n;
  logic [7:0]  data_out;
  logic        data_drv;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pos_byte_reader dut (
    .clk(clk), .rst_ax1_n(rst_ax1_n), .rst_ax2_n(rst_ax2_n),
    .count_ax1(count_ax1), .count_ax2(count_ax2), .axis_sel(axis_sel),
    .bsel1(bsel1), .bsel2(bsel2), .oe_n(oe_n),
    .data_out(data_out), .data_drv(data_drv)
  );

  // Code {bsel1,bsel2} for rank k (3 = top byte), per R1.
  function automatic logic [1:0] code_for(input int k);
    case (k)
      3: return 2'b01;
      2: return 2'b11;
      1: return 2'b00;
      default: return 2'b10;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_ctl(input logic oe, input logic ax, input logic [1:0] code);
    oe_n = oe; axis_sel = ax; {bsel1, bsel2} = code; #1;
  endtask

  // Read all four bytes, top byte first, leaving oe_n low.
  task automatic read_word(input logic ax, output logic [31:0] w);
    for (int k = 3; k >= 0; k--) begin
      set_ctl(1'b0, ax, code_for(k));
      w[k*8 +: 8] = data_out;
      tick();
    end
  endtask

  // Raise oe_n and let the release and the reload edges pass.
  task automatic release_bus();
    set_ctl(1'b1, 1'b0, 2'b00);
    tick(); tick();
  endtask

  task automatic t_reset_state();
    set_ctl(1'b1, 1'b0, 2'b01);
    check("R2 idle drv", {31'd0, data_drv}, 32'd0);
    check("R2 idle data", {24'd0, data_out}, 32'd0);
    set_ctl(1'b0, 1'b0, 2'b01);
    check("R8 reset latch", {24'd0, data_out}, 32'd0);
    check("R2 enabled drv", {31'd0, data_drv}, 32'd1);
    set_ctl(1'b1, 1'b0, 2'b01);
  endtask

  task automatic t_byte_codes();
    logic [31:0] w;
    count_ax1 = 32'h1122_3344; count_ax2 = 32'hA5B6_C7D8;
    tick(); tick();
    set_ctl(1'b0, 1'b0, 2'b01); check("R1 code 01", {24'd0, data_out}, 32'h11);
    set_ctl(1'b0, 1'b0, 2'b11); check("R1 code 11", {24'd0, data_out}, 32'h22);
    set_ctl(1'b0, 1'b0, 2'b00); check("R1 code 00", {24'd0, data_out}, 32'h33);
    set_ctl(1'b0, 1'b0, 2'b10); check("R1 code 10", {24'd0, data_out}, 32'h44);
    tick();
    release_bus();
    read_word(1'b1, w);
    check("R3 axis 2 word", w, 32'hA5B6_C7D8);
    release_bus();
    read_word(1'b0, w);
    check("R3 axis 1 word", w, 32'h1122_3344);
    release_bus();
  endtask

  task automatic t_tracking();
    logic [31:0] w;
    for (int i = 0; i < 5; i++) begin
      count_ax1 = 32'h0000_1000 + i * 32'h0101_0101;
      tick();
    end
    read_word(1'b0, w);
    check("R4 tracks last count", w, 32'h0404_1404);
    release_bus();
  endtask

  task automatic t_freeze_collision();
    logic [31:0] w;
    count_ax1 = 32'hCAFE_0001;
    tick();
    // Freeze and a count change in the same step.
    count_ax1 = 32'hDEAD_BEEF;
    set_ctl(1'b0, 1'b0, 2'b01);
    check("R5 snapshot on collision", {24'd0, data_out}, 32'hCA);
    tick();
    count_ax1 = 32'h1234_5678;
    tick();
    read_word(1'b0, w);
    check("R5 frozen word", w, 32'hCAFE_0001);
    release_bus();
    read_word(1'b0, w);
    check("R7 resumes after release", w, 32'h1234_5678);
    release_bus();
  endtask

  task automatic t_no_lsb_hold();
    logic [31:0] w;
    count_ax1 = 32'h0BAD_F00D;
    tick();
    set_ctl(1'b0, 1'b0, 2'b01); tick();
    set_ctl(1'b1, 1'b0, 2'b01);
    count_ax1 = 32'h7777_0000;
    tick(); tick(); tick();
    read_word(1'b0, w);
    check("R6 held without LSB", w, 32'h0BAD_F00D);
    release_bus();
    read_word(1'b0, w);
    check("R7 no counts lost", w, 32'h7777_0000);
    release_bus();
  endtask

  task automatic t_independence();
    logic [31:0] w;
    count_ax1 = 32'h0101_0101; count_ax2 = 32'h0202_0202;
    tick(); tick();
    set_ctl(1'b0, 1'b0, 2'b11); tick();
    set_ctl(1'b1, 1'b0, 2'b11);
    count_ax1 = 32'h0303_0303; count_ax2 = 32'h0404_0404;
    tick(); tick();
    read_word(1'b1, w);
    check("R9 other axis tracks", w, 32'h0404_0404);
    set_ctl(1'b1, 1'b0, 2'b00); tick(); tick();
    read_word(1'b0, w);
    check("R9 frozen axis kept", w, 32'h0101_0101);
    release_bus();
  endtask

  task automatic t_axis_reset();
    logic [31:0] w;
    count_ax1 = 32'h5555_AAAA; count_ax2 = 32'h6666_BBBB;
    tick(); tick();
    set_ctl(1'b0, 1'b0, 2'b01); tick();
    rst_ax1_n = 1'b0; #1;
    check("R8 axis 1 cleared", {24'd0, data_out}, 32'd0);
    set_ctl(1'b0, 1'b1, 2'b01);
    check("R8 axis 2 untouched", {24'd0, data_out}, 32'h66);
    set_ctl(1'b0, 1'b1, 2'b10); tick();
    set_ctl(1'b1, 1'b0, 2'b01);
    rst_ax1_n = 1'b1;
    tick(); tick();
    read_word(1'b0, w);
    check("R8 axis 1 reloads after reset", w, 32'h5555_AAAA);
    release_bus();
  endtask

  task automatic t_disabled_bus();
    count_ax1 = 32'hFFFF_FFFF;
    tick(); tick();
    for (int k = 0; k < 4; k++) begin
      set_ctl(1'b1, 1'b0, code_for(k));
      check("R2 quiet with oe_n high", {23'd0, data_drv, data_out}, 32'd0);
    end
  endtask

  initial begin
    rst_ax1_n = 1'b0; rst_ax2_n = 1'b0;
    count_ax1 = '0; count_ax2 = '0;
    axis_sel = 1'b0; bsel1 = 1'b0; bsel2 = 1'b0; oe_n = 1'b1;
    tick(); tick();
    t_reset_state();
    rst_ax1_n = 1'b1; rst_ax2_n = 1'b1;
    tick();
    t_byte_codes();
    t_tracking();
    t_freeze_collision();
    t_no_lsb_hold();
    t_independence();
    t_axis_reset();
    t_disabled_bus();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule